// File: doc/BRIEF.md
# Reverse-Subtract-Immediate Execute Unit

This unit executes a family of four subtract instructions that compute an immediate operand minus a register operand, in one clock. Each accepted instruction word arrives with the value of its source register. A subtract produces one result beat that carries the destination register index and the difference. Acceptance of the beat by the register file is the write. The unit keeps a one-bit carry flag. Two opcode bits decide whether the flag feeds the adder's carry-in and whether the adder's carry-out is written back. A carry of 1 means that no borrow occurred.

The immediate normally comes from the low 16 bits of the word, sign-extended. A prefix instruction that directly precedes a subtract in the accepted stream supplies the upper half of the immediate instead. The prefix is held across idle cycles. It is dropped by whichever valid instruction is accepted next. Any other opcode is accepted and produces no beat.

The input and output are valid/ready streams. The output holds one beat. When that beat is held because `res_ready` is low, `in_ready` drops. No new word is taken until the beat leaves. Both the beat and the carry flag then stay unchanged. A word is accepted when `in_valid` and `in_ready` are both high on a rising clock edge. A beat leaves when `res_valid` and `res_ready` are both high.

Top module: `rsi_exec`

## Requirements
- R1: An accepted subtract has opcode `in_instr[31:26]` matching `001xx1`. When the use-carry bit `in_instr[27]` is 0, it yields `res_data` = immediate − `in_ra` (mod 2^32), with `res_rd_idx` = `in_instr[25:21]`.
- R2: When no prefix is pending, the immediate is `in_instr[15:0]` sign-extended to 32 bits.
- R3: When the use-carry bit `in_instr[27]` is 1, the result is immediate + NOT `in_ra` + current carry flag.
- R4: When the keep-carry bit `in_instr[28]` is 0, the carry flag is loaded with the adder carry-out. For a plain subtract this is 1 exactly when immediate ≥ `in_ra` as unsigned values (no borrow).
- R5: When the keep-carry bit `in_instr[28]` is 1, the carry flag keeps its previous value.
- R6: An accepted prefix (opcode `101100`) stores `in_instr[15:0]`. The store survives idle cycles. The next accepted instruction consumes and clears it. A subtract that consumes it uses it as bits 31:16 of the immediate and its own `in_instr[15:0]` as bits 15:0. A prefix produces no beat.
- R7: An accepted word whose opcode is neither a subtract nor a prefix produces no beat, leaves the carry flag unchanged and discards a pending prefix.
- R8: The beat of a subtract is valid in the cycle after its acceptance. The carry flag updates on that same edge. In a cycle with no acceptance, the flag and the pending prefix do not change.
- R9: While `res_valid` is high and `res_ready` is low, `in_ready` is low, and `res_valid`, `res_data` and `res_rd_idx` hold.
- R10: A synchronous active-high `rst` clears the carry flag, the pending prefix and `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operand are present |
| in_ready | output | 1 | Unit can take a word this cycle |
| in_instr | input | 32 | Instruction word |
| in_ra | input | 32 | Value of the source register |
| res_valid | output | 1 | Result beat present (register write enable) |
| res_ready | input | 1 | Consumer takes the beat |
| res_rd_idx | output | 5 | Destination register index |
| res_data | output | 32 | Difference to write |
| carry_flag | output | 1 | Current carry flag (1 = no borrow) |

## Verification
The bound checker watches several rules on every cycle:
- the handshake rules: the hold under back-pressure and the ready drop;
- that a subtract yields a beat one cycle after acceptance and any other opcode yields none;
- that the flag holds when keep-carry is set or nothing is accepted;
- the arithmetic and the no-borrow flag of plain subtracts without a prefix;
- the arming and clearing of the prefix.

Some results depend on history, and only the bench's scenarios show them:
- results that chain the flag through use-carry, such as a two-word subtraction;
- widening by a prefix, across idle cycles as well;
- a prefix discarded by an unrelated opcode or by reset;
- the exact carry-out of carry-in subtracts.

// File: rtl/rsi_pkg.sv
`timescale 1ns/1ps
package rsi_pkg;
  localparam int DATA_W    = 32;
  localparam int IMM_W     = 16;
  localparam int OPC_W     = 6;
  localparam int IDX_W     = 5;
  localparam int KEEP_BIT  = 28;
  localparam int USE_BIT   = 27;
  localparam logic [OPC_W-1:0] SUB_OPC_BASE = 6'b001001;
  localparam logic [OPC_W-1:0] SUB_OPC_MASK = 6'b111001;
  localparam logic [OPC_W-1:0] PFX_OPC      = 6'b101100;

  typedef enum logic [1:0] {
    OP_OTHER = 2'd0,
    OP_SUB   = 2'd1,
    OP_PFX   = 2'd2
  } op_kind_e;

  typedef struct packed {
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
  } beat_t;
endpackage

// File: rtl/rsi_decode.sv
`timescale 1ns/1ps
module rsi_decode
  import rsi_pkg::*;
#(
  parameter int W     = DATA_W,
  parameter int IW    = IMM_W,
  parameter int OW    = OPC_W,
  parameter int XW    = IDX_W
) (
  input  logic [W-1:0]  instr,
  output op_kind_e      kind,
  output logic          keep_c,
  output logic          use_c,
  output logic [XW-1:0] rd_idx,
  output logic [IW-1:0] imm_field
);
  localparam int OPC_LSB = W - OW;
  localparam int IDX_LSB = OPC_LSB - XW;
  localparam int SRC_W   = IDX_LSB - IW;

  logic [OW-1:0]    opc;
  logic [SRC_W-1:0] unused_src_field;

  assign opc              = instr[W-1:OPC_LSB];
  assign rd_idx           = instr[IDX_LSB +: XW];
  assign imm_field        = instr[IW-1:0];
  assign unused_src_field = instr[IW +: SRC_W];
  assign keep_c           = instr[KEEP_BIT];
  assign use_c            = instr[USE_BIT];

  always_comb begin
    if ((opc & SUB_OPC_MASK) == SUB_OPC_BASE) kind = OP_SUB;
    else if (opc == PFX_OPC)                  kind = OP_PFX;
    else                                      kind = OP_OTHER;
  end
endmodule

// File: rtl/rsi_imm_unit.sv
`timescale 1ns/1ps
module rsi_imm_unit
  import rsi_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int IW = IMM_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          is_pfx,
  input  logic [IW-1:0] imm_field,
  output logic [W-1:0]  imm_op,
  output logic          pend
);
  localparam int HI_W = W - IW;

  logic [HI_W-1:0] hi_q;
  logic [HI_W-1:0] hi_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      hi_q <= '0;
    end else if (accept) begin
      pend <= is_pfx;
      if (is_pfx) hi_q <= imm_field[HI_W-1:0];
    end
  end

  generate
    if (HI_W > 0) begin : g_widen
      always_comb begin
        if (pend) hi_sel = hi_q;
        else      hi_sel = {HI_W{imm_field[IW-1]}};
      end
    end
  endgenerate

  assign imm_op = {hi_sel, imm_field};
endmodule

// File: rtl/rsi_rev_adder.sv
`timescale 1ns/1ps
module rsi_rev_adder #(
  parameter int W     = 32,
  parameter int SPLIT = 0
) (
  input  logic [W-1:0] imm_op,
  input  logic [W-1:0] reg_op,
  input  logic         cin,
  output logic [W-1:0] diff,
  output logic         cout
);
  localparam int LO_W = W / 2;
  localparam int HI_W = W - LO_W;

  logic [W-1:0] inv_reg;
  assign inv_reg = ~reg_op;

  generate
    if (SPLIT == 0) begin : g_flat
      logic [W:0] sum;
      assign sum  = {1'b0, imm_op} + {1'b0, inv_reg} + {{W{1'b0}}, cin};
      assign diff = sum[W-1:0];
      assign cout = sum[W];
    end else begin : g_halves
      logic [LO_W:0] lo_sum;
      logic [HI_W:0] hi_sum;
      assign lo_sum = {1'b0, imm_op[LO_W-1:0]} + {1'b0, inv_reg[LO_W-1:0]}
                    + {{LO_W{1'b0}}, cin};
      assign hi_sum = {1'b0, imm_op[W-1:LO_W]} + {1'b0, inv_reg[W-1:LO_W]}
                    + {{HI_W{1'b0}}, lo_sum[LO_W]};
      assign diff = {hi_sum[HI_W-1:0], lo_sum[LO_W-1:0]};
      assign cout = hi_sum[HI_W];
    end
  endgenerate
endmodule

// File: rtl/rsi_carry_flag.sv
`timescale 1ns/1ps
module rsi_carry_flag (
  input  logic clk,
  input  logic rst,
  input  logic upd,
  input  logic nxt,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (upd) flag <= nxt;
  end
endmodule

// File: rtl/rsi_exec.sv
`timescale 1ns/1ps
module rsi_exec
  import rsi_pkg::*;
#(
  parameter int W        = DATA_W,
  parameter int IW       = IMM_W,
  parameter int XW       = IDX_W,
  parameter int ADD_SPLIT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_instr,
  input  logic [W-1:0]  in_ra,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [XW-1:0] res_rd_idx,
  output logic [W-1:0]  res_data,
  output logic          carry_flag
);
  op_kind_e      kind;
  logic          keep_c;
  logic          use_c;
  logic [XW-1:0] rd_idx;
  logic [IW-1:0] imm_field;
  logic [W-1:0]  imm_op;
  logic          pfx_pend;
  logic [W-1:0]  diff;
  logic          cout;
  logic          cin;
  logic          accept;
  logic          acc_sub;
  beat_t         beat_q;

  rsi_decode #(.W(W), .IW(IW), .OW(OPC_W), .XW(XW)) u_dec (
    .instr     (in_instr),
    .kind      (kind),
    .keep_c    (keep_c),
    .use_c     (use_c),
    .rd_idx    (rd_idx),
    .imm_field (imm_field)
  );

  assign in_ready = !res_valid || res_ready;
  assign accept   = in_valid && in_ready;
  assign acc_sub  = accept && (kind == OP_SUB);

  rsi_imm_unit #(.W(W), .IW(IW)) u_imm (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .is_pfx    (kind == OP_PFX),
    .imm_field (imm_field),
    .imm_op    (imm_op),
    .pend      (pfx_pend)
  );

  assign cin = use_c ? carry_flag : 1'b1;

  rsi_rev_adder #(.W(W), .SPLIT(ADD_SPLIT)) u_add (
    .imm_op (imm_op),
    .reg_op (in_ra),
    .cin    (cin),
    .diff   (diff),
    .cout   (cout)
  );

  rsi_carry_flag u_flag (
    .clk  (clk),
    .rst  (rst),
    .upd  (acc_sub && !keep_c),
    .nxt  (cout),
    .flag (carry_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      beat_q    <= '0;
    end else begin
      if (accept)         res_valid <= acc_sub;
      else if (res_ready) res_valid <= 1'b0;
      if (acc_sub) begin
        beat_q.idx  <= rd_idx;
        beat_q.data <= diff;
      end
    end
  end

  assign res_rd_idx = beat_q.idx;
  assign res_data   = beat_q.data;
endmodule

// File: rtl/rsi_exec_chk.sv
`timescale 1ns/1ps
module rsi_exec_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_instr,
  input logic [31:0] in_ra,
  input logic        res_valid,
  input logic        res_ready,
  input logic [4:0]  res_rd_idx,
  input logic [31:0] res_data,
  input logic        carry_flag,
  input logic        pfx_pend
);
  logic        acc;
  logic        is_sub;
  logic        is_pfx;
  logic [31:0] sext_imm;

  assign acc      = in_valid && in_ready;
  assign is_sub   = (in_instr[31:29] == 3'b001) && in_instr[26];
  assign is_pfx   = (in_instr[31:26] == 6'b101100);
  assign sext_imm = {{16{in_instr[15]}}, in_instr[15:0]};

  AST_PLAIN_RESULT: assert property (@(posedge clk) disable iff (rst)
    acc && is_sub && !in_instr[27] && !pfx_pend |=>
      res_data == $past(sext_imm) - $past(in_ra)); // R1
  AST_PLAIN_NO_BORROW: assert property (@(posedge clk) disable iff (rst)
    acc && is_sub && !in_instr[27] && !in_instr[28] && !pfx_pend |=>
      carry_flag == ($past(sext_imm) >= $past(in_ra))); // R4
  AST_KEEP_HOLDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    acc && is_sub && in_instr[28] |=> $stable(carry_flag)); // R5
  AST_PFX_ARMS: assert property (@(posedge clk) disable iff (rst)
    acc && is_pfx |=> pfx_pend); // R6
  AST_PFX_CONSUMED: assert property (@(posedge clk) disable iff (rst)
    acc && !is_pfx |=> !pfx_pend); // R6
  AST_OTHER_NO_BEAT: assert property (@(posedge clk) disable iff (rst)
    acc && !is_sub |=> !res_valid); // R7
  AST_SUB_BEAT_NEXT: assert property (@(posedge clk) disable iff (rst)
    acc && is_sub |=> res_valid && res_rd_idx == $past(in_instr[25:21])); // R8
  AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(carry_flag) && $stable(pfx_pend)); // R8
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_ready |-> !in_ready); // R9
  AST_STALL_HOLDS_BEAT: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_ready |=>
      res_valid && $stable(res_data) && $stable(res_rd_idx)); // R9
endmodule

bind rsi_exec rsi_exec_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_instr   (in_instr),
  .in_ra      (in_ra),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_rd_idx (res_rd_idx),
  .res_data   (res_data),
  .carry_flag (carry_flag),
  .pfx_pend   (pfx_pend)
);

// File: tb/rsi_exec_test.sv
`timescale 1ns/1ps
module rsi_exec_test;
  localparam logic [5:0] O_SUB   = 6'b001001;
  localparam logic [5:0] O_SUBC  = 6'b001011;
  localparam logic [5:0] O_SUBK  = 6'b001101;
  localparam logic [5:0] O_SUBKC = 6'b001111;
  localparam logic [5:0] O_PFX   = 6'b101100;
  localparam logic [5:0] O_OTHER = 6'b000000;

  typedef struct packed {
    logic [5:0]  opc;
    logic [15:0] imm;
    logic [31:0] ra;
    logic        v;
    logic [31:0] d;
    logic        c;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [0:NV-1] = '{
    '{O_SUB,   16'h0010, 32'h5,        1'b1, 32'h0000000B, 1'b1, 4'd1}, // R1
    '{O_SUB,   16'h0003, 32'h5,        1'b1, 32'hFFFFFFFE, 1'b0, 4'd4}, // R4 borrow
    '{O_SUBK,  16'h0100, 32'h1,        1'b1, 32'h000000FF, 1'b0, 4'd5}, // R5
    '{O_SUBC,  16'h0005, 32'h2,        1'b1, 32'h00000002, 1'b1, 4'd3}, // R3 cin 0
    '{O_SUBC,  16'h0005, 32'h5,        1'b1, 32'h00000000, 1'b1, 4'd3}, // R3 cin 1
    '{O_SUBKC, 16'h0000, 32'h0,        1'b1, 32'h00000000, 1'b1, 4'd5}, // R5
    '{O_SUB,   16'h8000, 32'h0,        1'b1, 32'hFFFF8000, 1'b1, 4'd2}, // R2
    '{O_SUB,   16'hFFFF, 32'hFFFFFFFF, 1'b1, 32'h00000000, 1'b1, 4'd2}, // R2
    '{O_SUB,   16'h0000, 32'h1,        1'b1, 32'hFFFFFFFF, 1'b0, 4'd4}, // R4
    '{O_SUBC,  16'h0007, 32'h3,        1'b1, 32'h00000003, 1'b1, 4'd3}, // R3
    '{O_PFX,   16'h1234, 32'h0,        1'b0, 32'h0,        1'b1, 4'd6}, // R6
    '{O_SUB,   16'h8000, 32'h1,        1'b1, 32'h12347FFF, 1'b1, 4'd6}, // R6
    '{O_SUB,   16'h8000, 32'h0,        1'b1, 32'hFFFF8000, 1'b1, 4'd6}, // R6 cleared
    '{O_PFX,   16'hABCD, 32'h0,        1'b0, 32'h0,        1'b1, 4'd6}, // R6
    '{O_OTHER, 16'h0000, 32'h0,        1'b0, 32'h0,        1'b1, 4'd7}, // R7
    '{O_SUB,   16'h0001, 32'h0,        1'b1, 32'h00000001, 1'b1, 4'd7}, // R7 discarded
    '{O_PFX,   16'h0000, 32'h0,        1'b0, 32'h0,        1'b1, 4'd6}, // R6
    '{O_SUB,   16'hFFFF, 32'h0,        1'b1, 32'h0000FFFF, 1'b1, 4'd6}, // R6 no sext
    '{O_SUB,   16'h0000, 32'h0,        1'b1, 32'h00000000, 1'b1, 4'd1}  // R1
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_instr;
  logic [31:0] in_ra;
  logic        res_valid;
  logic        res_ready;
  logic [4:0]  res_rd_idx;
  logic [31:0] res_data;
  logic        carry_flag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rsi_exec uut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_instr   (in_instr),
    .in_ra      (in_ra),
    .res_valid  (res_valid),
    .res_ready  (res_ready),
    .res_rd_idx (res_rd_idx),
    .res_data   (res_data),
    .carry_flag (carry_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input logic [5:0] opc, input logic [4:0] rd,
                                       input logic [15:0] imm);
    return {opc, rd, 5'd0, imm};
  endfunction

  task automatic issue(input logic [5:0] opc, input logic [4:0] rd,
                       input logic [15:0] imm, input logic [31:0] ra);
    @(negedge clk);
    in_valid = 1'b1;
    in_instr = word(opc, rd, imm);
    in_ra    = ra;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_instr = '0; in_ra = '0; res_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk("R10 res_valid", {31'd0, res_valid}, 32'd0);
    chk("R10 carry", {31'd0, carry_flag}, 32'd0);
    chk("R10 in_ready", {31'd0, in_ready}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      issue(VECS[i].opc, 5'(i), VECS[i].imm, VECS[i].ra);
      chk(tag, {31'd0, res_valid}, {31'd0, VECS[i].v});
      if (VECS[i].v) begin
        chk(tag, res_data, VECS[i].d);
        chk(tag, {27'd0, res_rd_idx}, {27'd0, 5'(i)});
      end
      chk(tag, {31'd0, carry_flag}, {31'd0, VECS[i].c});
    end

    // R9 back-pressure and R8 latency
    @(negedge clk);
    res_ready = 1'b0;
    in_valid = 1'b1; in_instr = word(O_SUB, 5'd3, 16'h0020); in_ra = 32'h10;
    @(negedge clk);
    chk("R8 beat after one cycle", {31'd0, res_valid}, 32'd1);
    chk("R8 data", res_data, 32'h10);
    in_instr = word(O_SUB, 5'd4, 16'h0000); in_ra = 32'h1;
    chk("R9 in_ready low", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    chk("R9 beat held", res_data, 32'h10);
    chk("R9 idx held", {27'd0, res_rd_idx}, 32'd3);
    chk("R9 flag untouched", {31'd0, carry_flag}, 32'd1);
    res_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 next beat", res_data, 32'hFFFFFFFF);
    chk("R9 next idx", {27'd0, res_rd_idx}, 32'd4);
    chk("R9 next flag", {31'd0, carry_flag}, 32'd0);
    @(negedge clk);
    chk("R8 beat drained", {31'd0, res_valid}, 32'd0);

    // R6: prefix survives idle cycles
    issue(O_PFX, 5'd0, 16'h00FF, 32'h0);
    repeat (3) @(negedge clk);
    chk("R8 idle keeps flag", {31'd0, carry_flag}, 32'd0);
    issue(O_SUB, 5'd7, 16'h0000, 32'h0);
    chk("R6 prefix after idle", res_data, 32'h00FF0000);
    chk("R4 flag no borrow", {31'd0, carry_flag}, 32'd1);

    // R7: unrelated opcode leaves flag at 0
    issue(O_SUB, 5'd1, 16'h0000, 32'h2);
    chk("R4 borrow", {31'd0, carry_flag}, 32'd0);
    issue(O_OTHER, 5'd1, 16'hFFFF, 32'h0);
    chk("R7 no beat", {31'd0, res_valid}, 32'd0);
    chk("R7 flag kept", {31'd0, carry_flag}, 32'd0);

    // R3: two-word subtraction 0x1_00000000 - 0x1
    issue(O_SUB, 5'd2, 16'h0000, 32'h1);
    chk("R3 low word", res_data, 32'hFFFFFFFF);
    issue(O_SUBC, 5'd3, 16'h0001, 32'h0);
    chk("R3 high word", res_data, 32'h00000000);
    chk("R3 high carry", {31'd0, carry_flag}, 32'd1);

    // R10: reset drops pending prefix and flag
    issue(O_PFX, 5'd0, 16'h7777, 32'h0);
    do_reset();
    chk("R10 flag after reset", {31'd0, carry_flag}, 32'd0);
    chk("R10 no beat after reset", {31'd0, res_valid}, 32'd0);
    issue(O_SUBK, 5'd5, 16'h0001, 32'h0);
    chk("R10 prefix dropped", res_data, 32'h00000001);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule